// File: doc/BRIEF.md
# Sparse Polyphase Filter Matrix for a 64-Channel, Decimate-by-48 Filter Bank

This block sits between the input commutator and the transform stage of an oversampled analysis filter bank. The bank has 64 channels and a decimation factor of 48. Once per frame the block takes 48 parallel input samples and computes 64 filtered outputs. The frame is one decimated time step.

The matrix is sparse. The common divisor of 64 and 48 is 16 and their least common multiple is 192, so a 768-tap prototype splits into 192 branch filters of four taps each. Input lane `j` drives four branches, `k = j + 48l` for `l = 0..3`. Branch `k` delays its contribution by `l` frames and adds it into output row `k mod 64`. Its own taps `h[192n + k]` sit four frames apart. Every output row collects exactly three branch products.

The coefficients are fixed at elaboration. They are built by a hash function in the package from the `SEED` parameter and stored in a constant array of 13-bit signed values. One frame is computed in 48 steps. In each step one input lane is processed through 16 multipliers against the frame history.

Top module: `ovs_poly_matrix`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid` goes low and `u_out` goes to zero. The frame history is cleared, so the first frames after reset give the response to all-zero earlier inputs.
- R2: Input lane `j` is `a_in[12j+11:12j]` and output row `r` is `u_out[16r+15:16r]`, both two's complement. For frame `m`, the exact sum for row `r` is S_r[m] = sum of h[t]·A_{k mod 48}[m − (k div 48) − 4n]. The sum runs over every tap t in 0..767 with k = t mod 192, n = t div 192 and k mod 64 = r.
- R3: Input lane `j` feeds the branches k = j + 48l, l = 0..3. Each branch reaches row (j + 48l) mod 64 delayed by `l` frames, so every row is the sum of exactly three branches.
- R4: Within branch `k`, tap `h[192n + k]` applies to the input `4n` frames older than the branch's own delay, for n = 0..3.
- R5: Each coefficient h[t] is the low 13 bits of `pm_pkg::tap_value(SEED, t)`, read as signed. Each output equals the low 16 bits of floor((S + 256) / 512). This is a scale by one half with four fraction bits kept, rounded to nearest with ties upward, and any excess wraps.
- R6: `out_valid` is a one-cycle pulse on the 49th rising edge after the edge that accepts `frame_in`. `u_out` changes only on that edge and holds its value otherwise.
- R7: `frame_in` is ignored during the 48 cycles after acceptance. It does not advance the history, does not change the outputs and produces no extra `out_valid`.
- R8: Frames may be accepted every 49 cycles back to back, and each one still gives the R2 result.
- R9: Inputs at the extremes of −2048 and +2047 give the R2/R5 result, with no loss inside the accumulation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_in | input | 1 | Strobe that accepts `a_in` as a new frame when idle |
| a_in | input | 576 | 48 signed 12-bit samples, lane j at bits 12j+11:12j |
| out_valid | output | 1 | One-cycle pulse marking fresh `u_out` |
| u_out | output | 1024 | 64 signed 16-bit outputs, row r at bits 16r+15:16r |

## Verification
The bench sends single-lane impulses at lanes 5 and 47, each followed by sixteen zero frames. This exposes every tap on its own, in a known frame and row. A wrong row rotation, a branch delay of the wrong length or a swapped tap index moves a coefficient to another row or frame. Full-scale alternating frames and random frames exercise the round-half-up step and the 16-bit wrap. A design that rounded toward zero or saturated would miss by one LSB or clip.

Back-to-back frames at the minimum spacing catch an accumulator that is cleared late or a result that is read early. A `frame_in` during the computation must leave no trace. A design that accepted it would emit an extra pulse or shift the history, and every later frame would then mismatch.

// File: rtl/pm_pkg.sv
`timescale 1ns/1ps
package pm_pkg;

  function automatic int gcd(input int a, input int b);
    int x;
    int y;
    int t;
    x = a;
    y = b;
    while (y != 0) begin
      t = x % y;
      x = y;
      y = t;
    end
    return x;
  endfunction

  function automatic int lcm(input int a, input int b);
    return (a / gcd(a, b)) * b;
  endfunction

  // Deterministic coefficient generator; caller keeps the low bits it needs.
  function automatic logic [31:0] tap_value(input int unsigned seed, input int unsigned idx);
    logic [31:0] x;
    x = idx * 32'h9E3779B1 + seed * 32'h85EBCA6B + 32'h01234567;
    x = x ^ (x >> 15);
    x = x * 32'h2C1B3C6D;
    x = x ^ (x >> 12);
    return x;
  endfunction

endpackage

// File: rtl/pm_frame_hist.sv
`timescale 1ns/1ps
module pm_frame_hist #(
  parameter int N_IN  = 48,
  parameter int IN_W  = 12,
  parameter int DEPTH = 16,
  localparam int SW   = $clog2(N_IN)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   shift_en,
  input  logic [N_IN*IN_W-1:0]   frame_data,
  input  logic [SW-1:0]          sel,
  output logic signed [IN_W-1:0] col [DEPTH]
);

  logic signed [IN_W-1:0] hist [DEPTH][N_IN];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int d = 0; d < DEPTH; d++)
        for (int j = 0; j < N_IN; j++)
          hist[d][j] <= '0;
    end else if (shift_en) begin
      for (int j = 0; j < N_IN; j++)
        hist[0][j] <= frame_data[j*IN_W +: IN_W];
      for (int d = 1; d < DEPTH; d++)
        hist[d] <= hist[d-1];
    end
  end

  always_comb begin
    for (int d = 0; d < DEPTH; d++)
      col[d] = hist[d][sel];
  end

  // R7
  hist_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(hist[DEPTH-1][N_IN-1]) && $stable(hist[0][0]));

endmodule

// File: rtl/pm_seq.sv
`timescale 1ns/1ps
module pm_seq #(
  parameter int STEPS = 48,
  localparam int CW   = $clog2(STEPS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_req,
  output logic          accept,
  output logic          busy,
  output logic          last,
  output logic [CW-1:0] step
);

  assign accept = start_req && !busy;
  assign last   = busy && (step == CW'(STEPS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      step <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      step <= '0;
    end else if (busy) begin
      busy <= !last;
      step <= last ? '0 : step + 1'b1;
    end
  end

  // R6
  step_range_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> step < CW'(STEPS));

  // R7
  start_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start_req));

endmodule

// File: rtl/pm_lane_bank.sv
`timescale 1ns/1ps
module pm_lane_bank #(
  parameter int N_IN   = 48,
  parameter int N_OUT  = 64,
  parameter int NTAP   = 4,
  parameter int IN_W   = 12,
  parameter int COEF_W = 13,
  parameter int ACC_W  = 30,
  parameter int unsigned SEED = 1,
  localparam int K     = pm_pkg::lcm(N_IN, N_OUT),
  localparam int BR    = K / N_IN,
  localparam int LANES = BR * NTAP,
  localparam int TOTAL = K * NTAP,
  localparam int SW    = $clog2(N_IN),
  localparam int IW    = $clog2(TOTAL)
) (
  input  logic [SW-1:0]           sel,
  input  logic signed [IN_W-1:0]  col    [LANES],
  output logic signed [ACC_W-1:0] br_sum [BR]
);

  logic signed [COEF_W-1:0] h_rom [TOTAL];
  logic signed [ACC_W-1:0]  prod  [LANES];

  for (genvar t = 0; t < TOTAL; t++) begin : g_rom
    localparam logic [31:0] RAW = pm_pkg::tap_value(SEED, t);
    assign h_rom[t] = RAW[COEF_W-1:0];
  end

  // Lane d is frame delay d = l + BR*n: branch l, tap n.
  for (genvar d = 0; d < LANES; d++) begin : g_lane
    localparam int LB = d % BR;
    localparam int NB = d / BR;
    logic [IW-1:0] idx;
    assign idx     = IW'(K * NB + N_IN * LB) + IW'(sel);
    assign prod[d] = ACC_W'(col[d]) * ACC_W'(h_rom[idx]);
  end

  always_comb begin
    for (int l = 0; l < BR; l++) begin
      br_sum[l] = '0;
      for (int n = 0; n < NTAP; n++)
        br_sum[l] = br_sum[l] + prod[l + BR*n];
    end
  end

endmodule

// File: rtl/ovs_poly_matrix.sv
`timescale 1ns/1ps
module ovs_poly_matrix #(
  parameter int N_IN   = 48,
  parameter int N_OUT  = 64,
  parameter int NTAP   = 4,
  parameter int IN_W   = 12,
  parameter int COEF_W = 13,
  parameter int OUT_W  = 16,
  parameter int unsigned SEED = 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    frame_in,
  input  logic [N_IN*IN_W-1:0]    a_in,
  output logic                    out_valid,
  output logic [N_OUT*OUT_W-1:0]  u_out
);

  localparam int K     = pm_pkg::lcm(N_IN, N_OUT);
  localparam int BR    = K / N_IN;
  localparam int ROWS  = K / N_OUT;
  localparam int LANES = BR * NTAP;
  localparam int ACC_W = IN_W + COEF_W + $clog2(ROWS * NTAP) + 1;
  localparam int SHIFT = COEF_W - (OUT_W - IN_W);
  localparam int SW    = $clog2(N_IN);
  localparam int RW    = $clog2(N_OUT);
  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) <<< (SHIFT - 1);

  logic                    accept, busy, last, done_q;
  logic [SW-1:0]           step;
  logic signed [IN_W-1:0]  col    [LANES];
  logic signed [ACC_W-1:0] br_sum [BR];
  logic signed [ACC_W-1:0] acc    [N_OUT];
  logic [RW-1:0]           row_of [BR];

  pm_seq #(.STEPS(N_IN)) seq_i (
    .clk(clk), .rst(rst), .start_req(frame_in),
    .accept(accept), .busy(busy), .last(last), .step(step)
  );

  pm_frame_hist #(.N_IN(N_IN), .IN_W(IN_W), .DEPTH(LANES)) hist_i (
    .clk(clk), .rst(rst), .shift_en(accept), .frame_data(a_in),
    .sel(step), .col(col)
  );

  pm_lane_bank #(
    .N_IN(N_IN), .N_OUT(N_OUT), .NTAP(NTAP), .IN_W(IN_W),
    .COEF_W(COEF_W), .ACC_W(ACC_W), .SEED(SEED)
  ) bank_i (
    .sel(step), .col(col), .br_sum(br_sum)
  );

  always_comb begin
    for (int l = 0; l < BR; l++)
      row_of[l] = RW'((int'(step) + N_IN * l) % N_OUT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      done_q    <= 1'b0;
      u_out     <= '0;
      for (int r = 0; r < N_OUT; r++) acc[r] <= '0;
    end else begin
      done_q    <= last;
      out_valid <= done_q;
      for (int r = 0; r < N_OUT; r++) begin
        if (accept)
          acc[r] <= '0;
        else if (busy)
          for (int l = 0; l < BR; l++)
            if (row_of[l] == RW'(r))
              acc[r] <= acc[r] + br_sum[l];
        if (done_q)
          u_out[r*OUT_W +: OUT_W] <= OUT_W'((acc[r] + HALF) >>> SHIFT);
      end
    end
  end

  // R1
  rst_quiet_chk: assert property (@(posedge clk)
    rst |=> !out_valid && (u_out == '0));

  // R6
  out_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R6
  done_follow_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |=> out_valid);

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(u_out));

  // R7
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    busy && frame_in && !last |=> busy && !out_valid);

endmodule

// File: tb/ovs_poly_matrix_tb_top.sv
`timescale 1ns/1ps
module ovs_poly_matrix_tb_top;

  localparam int N_IN = 48, N_OUT = 64, NTAP = 4, IN_W = 12, COEF_W = 13, OUT_W = 16;
  localparam int unsigned SEED = 7;
  localparam int K     = pm_pkg::lcm(N_IN, N_OUT);
  localparam int BR    = K / N_IN;
  localparam int DEPTH = BR * NTAP;
  localparam int TOTAL = K * NTAP;
  localparam int LAT   = N_IN + 1;
  localparam int SHIFT = COEF_W - (OUT_W - IN_W);

  logic clk = 1'b0, rst = 1'b1, frame_in = 1'b0;
  logic [N_IN*IN_W-1:0]   a_in = '0;
  logic                   out_valid;
  logic [N_OUT*OUT_W-1:0] u_out;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int bh [DEPTH][N_IN];
  logic [N_OUT*OUT_W-1:0] exp_q [$];
  int                     due_q [$];
  string                  tag_q [$];
  logic [N_OUT*OUT_W-1:0] last_u = '0;
  logic [N_OUT*OUT_W-1:0] m_exp;
  int                     m_due;
  string                  m_tag;

  ovs_poly_matrix #(.N_IN(N_IN), .N_OUT(N_OUT), .NTAP(NTAP), .IN_W(IN_W),
                    .COEF_W(COEF_W), .OUT_W(OUT_W), .SEED(SEED)) dut_i (
    .clk(clk), .rst(rst), .frame_in(frame_in), .a_in(a_in),
    .out_valid(out_valid), .u_out(u_out)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [N_OUT*OUT_W-1:0] model();
    longint s [N_OUT];
    longint q;
    logic [N_OUT*OUT_W-1:0] v;
    logic [31:0] raw;
    int n, k, d;
    for (int r = 0; r < N_OUT; r++) s[r] = 0;
    for (int t = 0; t < TOTAL; t++) begin
      n = t / K;
      k = t % K;
      d = k / N_IN + BR * n;
      raw = pm_pkg::tap_value(SEED, t);
      s[k % N_OUT] += longint'($signed(raw[COEF_W-1:0])) * longint'(bh[d][k % N_IN]);
    end
    for (int r = 0; r < N_OUT; r++) begin
      q = (s[r] + (longint'(1) <<< (SHIFT - 1))) >>> SHIFT;
      v[r*OUT_W +: OUT_W] = q[OUT_W-1:0];
    end
    return v;
  endfunction

  function automatic logic [N_IN*IN_W-1:0] rnd_frame();
    logic [N_IN*IN_W-1:0] f;
    for (int j = 0; j < N_IN; j++) f[j*IN_W +: IN_W] = IN_W'($urandom);
    return f;
  endfunction

  function automatic logic [N_IN*IN_W-1:0] fill(input logic [IN_W-1:0] val);
    logic [N_IN*IN_W-1:0] f;
    for (int j = 0; j < N_IN; j++) f[j*IN_W +: IN_W] = val;
    return f;
  endfunction

  // Driver: apply one frame, advance the reference history, queue the expectation.
  task automatic send(input string tag, input logic [N_IN*IN_W-1:0] data, input int gap);
    a_in = data;
    frame_in = 1'b1;
    @(posedge clk);
    @(negedge clk);
    frame_in = 1'b0;
    for (int d = DEPTH - 1; d > 0; d--)
      for (int j = 0; j < N_IN; j++) bh[d][j] = bh[d-1][j];
    for (int j = 0; j < N_IN; j++) bh[0][j] = int'($signed(data[j*IN_W +: IN_W]));
    exp_q.push_back(model());
    due_q.push_back(cyc + LAT);
    tag_q.push_back(tag);
    repeat (gap - 1) @(negedge clk);
  endtask

  // Strobe while busy: the reference model must not move (R7).
  task automatic poke(input logic [N_IN*IN_W-1:0] data);
    a_in = data;
    frame_in = 1'b1;
    @(posedge clk);
    @(negedge clk);
    frame_in = 1'b0;
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          n_chk++; n_bad++;
          $display("FAIL R7: stray out_valid at cycle %0d, got 1 expected 0", cyc);
        end else begin
          m_exp = exp_q.pop_front();
          m_due = due_q.pop_front();
          m_tag = tag_q.pop_front();
          n_chk++;
          if (cyc != m_due) begin
            n_bad++;
            $display("FAIL R6: out_valid at cycle %0d expected cycle %0d", cyc, m_due);
          end
          for (int r = 0; r < N_OUT; r++) begin
            n_chk++;
            if (u_out[r*OUT_W +: OUT_W] !== m_exp[r*OUT_W +: OUT_W]) begin
              n_bad++;
              $display("FAIL %s: row %0d got %0d expected %0d", m_tag, r,
                       $signed(u_out[r*OUT_W +: OUT_W]), $signed(m_exp[r*OUT_W +: OUT_W]));
            end
          end
        end
        last_u = u_out;
      end else begin
        n_chk++;
        if (u_out !== last_u) begin
          n_bad++;
          $display("FAIL R6: u_out moved without out_valid, got %h expected %h", u_out, last_u);
        end
      end
    end
  end

  initial begin
    logic [N_IN*IN_W-1:0] imp;
    for (int d = 0; d < DEPTH; d++)
      for (int j = 0; j < N_IN; j++) bh[d][j] = 0;
    repeat (5) @(negedge clk);
    // R1: reset state
    n_chk++;
    if (out_valid !== 1'b0 || u_out !== '0) begin
      n_bad++;
      $display("FAIL R1: reset state got valid=%b out=%h expected 0", out_valid, u_out);
    end
    rst = 1'b0;
    @(negedge clk);
    // R1: first frame sees an all-zero history
    send("R1", rnd_frame(), 60);
    // R3 / R4: impulse on lane 5, then sixteen zero frames expose each tap
    imp = '0;
    imp[5*IN_W +: IN_W] = 12'd1000;
    send("R3", imp, 55);
    for (int i = 0; i < DEPTH; i++) send("R4", '0, 55);
    // R3 / R4: impulse on lane 47 with value -1, row wrap and small-value rounding
    imp = '0;
    imp[47*IN_W +: IN_W] = '1;
    send("R3", imp, 55);
    for (int i = 0; i < DEPTH; i++) send("R4", '0, 55);
    // R9: full-scale inputs
    for (int i = 0; i < 20; i++)
      send("R9", (i % 3 == 0) ? fill(12'h800) : fill(12'h7FF), 55);
    // R5: rounding and wrap on random data
    for (int i = 0; i < 20; i++) send("R5", rnd_frame(), 52);
    // R8: minimum spacing
    for (int i = 0; i < 20; i++) send("R8", rnd_frame(), LAT);
    // R7: strobes during computation are dropped
    for (int i = 0; i < 6; i++) begin
      send("R7", rnd_frame(), 20);
      poke(rnd_frame());
      repeat (35) @(negedge clk);
    end
    // R2: general random traffic with varied spacing
    for (int i = 0; i < 20; i++) send("R2", rnd_frame(), LAT + (i % 7));
    repeat (LAT + 5) @(negedge clk);
    n_chk++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R6: %0d frames without out_valid, expected 0", exp_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R6: watchdog expired, got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule